// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read engine of a 16-bit parallel NOR memory. A single configuration word picks between an asynchronous pass-through mode and a clocked burst mode. In burst mode a one-cycle address strobe latches a start address. The block then waits a programmable number of clocks and streams a run of data words. Each word's address comes from a counter that either runs linearly or wraps inside an aligned window of 4, 8 or 16 words. A continuous setting streams until the next strobe or until the mode changes.

The memory array sits outside the block as a combinational lookup: the block drives `mem_addr` and takes the word on `mem_data` in the same cycle. A WAIT output tells the host when data is not yet ready. Its active level is configurable. It can release either together with the first word or one data period ahead of it. Further fields choose a one- or two-clock hold per word and which clock edge the burst logic uses.

The configuration register always loads on the rising edge of `clk`. An unsupported combination of fields raises `cfg_err` and the block falls back to a safe setting. An overview of the configuration word, bit 0 first:

| Bits | Field | Values |
|---|---|---|
| [0] | mode | 1 = async pass-through, 0 = burst |
| [3:1] | length code | 001 = 4, 010 = 8, 011 = 16, 111 = continuous; other codes reserved |
| [4] | linear | 1 = linear addressing, 0 = wrap within the length |
| [5] | rising edge | 1 = rising edge of `clk`, 0 = falling edge |
| [6] | early WAIT | 1 = release WAIT one data period before the first word, 0 = release with it |
| [7] | two-clock hold | 1 = each word held two clocks, 0 = one clock |
| [8] | WAIT level | 1 = active high, 0 = active low |
| [12:9] | latency | L |
| [15:13] | reserved | read as zero |

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration reads 16'h09FF. This value selects async mode, continuous length, linear addressing, rising edge, early WAIT, two-clock hold, active-high WAIT and latency 4. In async mode `dq_valid` is 1.
- R2: Bits [15:13] of `cfg_q` always read zero, whatever value was written. The other bits read back exactly as written.
- R3: In async mode (bit 0 = 1), `mem_addr` follows `addr_in` and `dq_out` shows the addressed word in the same cycle. `dq_valid` is 1, WAIT sits at its inactive level and the strobe has no effect.
- R4: In burst mode (bit 0 = 0), a strobe latches `addr_in`. The first word appears after the L-th active edge, counting the edge that samples the strobe as the first.
- R5: A burst with code 001, 010 or 011 outputs exactly 4, 8 or 16 words and then returns to idle (`dq_valid` = 0, `dq_out` = 0). Code 111 streams words until the next strobe or until async mode is selected. Linear addresses roll over modulo 2^AW.
- R6: With wrap selected (bit 4 = 0) and a finite length N, word i is read from address (A & ~(N-1)) | ((A+i) & (N-1)), where A is the start address. With bit 4 = 1, word i is read from A+i.
- R7: Each word is held on `dq_out` for one active edge when bit 7 = 0 and for two active edges when bit 7 = 1.
- R8: WAIT is driven high when asserted if bit 8 = 1 and low when asserted if bit 8 = 0. When deasserted it sits at the opposite level.
- R9: WAIT is asserted during the latency wait and deasserted while data is valid and while idle.
  - With bit 6 = 0, WAIT deasserts in the same cycle as the first word.
  - With bit 6 = 1, WAIT deasserts H clocks earlier, where H is the hold (1 or 2).
- R10: Latency 2 combined with two-clock hold and early WAIT is unsupported. This combination raises `cfg_err`, and WAIT then deasserts together with the first word.
- R11: A reserved length code raises `cfg_err` and the burst behaves as continuous. A latency of 0 or 1 raises `cfg_err` and the block uses latency 4.
- R12: A strobe during an active burst, whether in the latency wait or in data, aborts that burst. A new latency count starts from the new address.
- R13: With bit 5 = 0, the burst logic samples the strobe and updates its outputs on the falling edge of `clk`. Timing relative to that edge is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Load the configuration word |
| cfg_wdata | input | 16 | Configuration value to load |
| addr_strobe | input | 1 | Address-valid strobe, active high |
| addr_in | input | AW | Start address in burst mode, live address in async mode |
| mem_addr | output | AW | Address sent to the array lookup |
| mem_data | input | 16 | Word returned by the array lookup |
| dq_out | output | 16 | Data bus; 0 when not valid |
| dq_valid | output | 1 | `dq_out` carries a valid word |
| wait_out | output | 1 | WAIT indication, level set by bit 8 |
| cfg_err | output | 1 | Configuration is unsupported or reserved |
| cfg_q | output | 16 | Configuration readback |

## Verification
The bench drives these corner cases:
- **Window boundaries.** Wrapping bursts start just below the end of their aligned window. A wrong modulo would step outside the window, or carry into the upper address bits.
- **Continuous rollover.** A continuous burst crosses the top of the address space. A counter that saturated or stopped there would be caught.
- **Latency edges.** Latencies 2 and 7, reserved latencies and the unsupported early-WAIT case all run. An off-by-one count shifts the first word by a cycle, and a missed fallback releases WAIT two clocks too early or stalls the burst.
- **Aborts and falling edge.** Strobes arrive mid-latency and mid-data, and bursts run on the falling edge. A design that ignored the abort, or kept using the rising edge, would show its data one cycle late or from the old address.

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [15:0]   cfg_wdata,
  input  logic          addr_strobe,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_data,
  output logic [15:0]   dq_out,
  output logic          dq_valid,
  output logic          wait_out,
  output logic          cfg_err,
  output logic [15:0]   cfg_q
);
  localparam logic [15:0] CFG_RST  = 16'h09FF;
  localparam logic [15:0] CFG_MASK = 16'h1FFF;
  localparam logic [3:0]  LAT_DEF  = 4'd4;

  typedef enum logic [1:0] {S_IDLE, S_LAT, S_DATA} st_t;

  logic [15:0] cfg;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg <= CFG_RST;
    else if (cfg_wr) cfg <= cfg_wdata & CFG_MASK;
  assign cfg_q = cfg;

  wire       async_m   = cfg[0];
  wire [2:0] bl        = cfg[3:1];
  wire       linear    = cfg[4];
  wire       rise      = cfg[5];
  wire       early_req = cfg[6];
  wire       hold2     = cfg[7];
  wire       whigh     = cfg[8];
  wire [3:0] lat_req   = cfg[12:9];

  wire bl_bad    = !(bl == 3'b001 || bl == 3'b010 || bl == 3'b011 || bl == 3'b111);
  wire lat_bad   = lat_req < 4'd2;
  wire combo_bad = (lat_req == 4'd2) && hold2 && early_req;
  assign cfg_err = bl_bad | lat_bad | combo_bad;

  wire       cont    = bl_bad || (bl == 3'b111);
  wire       wrap    = !linear && !cont;
  wire [3:0] lat_eff = lat_bad ? LAT_DEF : lat_req;
  wire       early   = early_req && !combo_bad;
  wire [3:0] gap     = early ? (hold2 ? 4'd2 : 4'd1) : 4'd0;

  logic [AW-1:0] len_mask;
  always_comb
    case (bl)
      3'b001:  len_mask = AW'(3);
      3'b010:  len_mask = AW'(7);
      3'b011:  len_mask = AW'(15);
      default: len_mask = '0;
    endcase

  logic eclk;
  assign eclk = rise ? clk : ~clk;

  st_t           st;
  logic [3:0]    cnt;
  logic [AW-1:0] base, off;
  logic          hph;

  wire last = !cont && (off == len_mask);

  always_ff @(posedge eclk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; base <= '0; off <= '0; hph <= 1'b0;
    end else if (async_m) begin
      st <= S_IDLE;
    end else if (addr_strobe) begin
      st   <= S_LAT;
      cnt  <= lat_eff - 4'd1;
      base <= addr_in;
      off  <= '0;
      hph  <= 1'b0;
    end else begin
      case (st)
        S_LAT: begin
          cnt <= cnt - 4'd1;
          if (cnt == 4'd1) st <= S_DATA;
        end
        S_DATA:
          if (hold2 && !hph) hph <= 1'b1;
          else begin
            hph <= 1'b0;
            if (last) st <= S_IDLE;
            else off <= off + AW'(1);
          end
        default: ;
      endcase
    end

  wire [AW-1:0] lin_addr  = base + off;
  wire [AW-1:0] wrap_addr = (base & ~len_mask) | (lin_addr & len_mask);

  assign mem_addr = async_m ? addr_in : (wrap ? wrap_addr : lin_addr);
  assign dq_valid = async_m || (st == S_DATA);
  assign dq_out   = dq_valid ? mem_data : 16'h0000;

  wire wait_act = !async_m && (st == S_LAT) && (cnt > gap);
  assign wait_out = whigh ? wait_act : !wait_act;
endmodule

module burst_read_seq_chk #(
  parameter int AW = 16
) (
  input logic          eclk,
  input logic          rst_n,
  input logic          addr_strobe,
  input logic          dq_valid,
  input logic          wait_out,
  input logic [15:0]   cfg_q,
  input logic [AW-1:0] mem_addr
);
  a_r12_strobe_blanks_data: assert property (@(posedge eclk) disable iff (!rst_n)
    (!cfg_q[0] && addr_strobe) |=> (cfg_q[0] || !dq_valid));

  a_r9_wait_idle_with_data: assert property (@(posedge eclk) disable iff (!rst_n)
    dq_valid |-> (wait_out == !cfg_q[8]));

  a_r7_hold2_repeats: assert property (@(posedge eclk) disable iff (!rst_n)
    (!cfg_q[0] && cfg_q[7] && $rose(dq_valid) && !addr_strobe)
      |=> (cfg_q[0] || (dq_valid && $stable(mem_addr))));

  a_r6_wrap_stays_aligned: assert property (@(posedge eclk) disable iff (!rst_n)
    (!cfg_q[0] && !cfg_q[4] && cfg_q[3:1] == 3'b001 && dq_valid
      && $past(dq_valid) && $past(cfg_q[4:0]) == cfg_q[4:0])
      |-> (mem_addr[AW-1:2] == $past(mem_addr[AW-1:2])));
endmodule

bind burst_read_seq burst_read_seq_chk #(.AW(AW)) u_chk (
  .eclk(eclk), .rst_n(rst_n), .addr_strobe(addr_strobe), .dq_valid(dq_valid),
  .wait_out(wait_out), .cfg_q(cfg_q), .mem_addr(mem_addr)
);

// File: tb/burst_read_seq_test.sv
`timescale 1ns/100ps
module burst_read_seq_test;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_strobe = 1'b0, s_wr = 1'b0;
  logic [15:0] s_wdata = '0;
  logic [AW-1:0] s_addr = '0;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_data, dq_out, cfg_q;
  logic dq_valid, wait_out, cfg_err;

  always #2 clk = ~clk;

  function automatic logic [15:0] memf(input logic [AW-1:0] a);
    return 16'(32'(a) * 32'd40503) ^ 16'h3C5A;
  endfunction
  assign mem_data = memf(mem_addr);

  burst_read_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(s_wr), .cfg_wdata(s_wdata),
    .addr_strobe(s_strobe), .addr_in(s_addr), .mem_addr(mem_addr),
    .mem_data(mem_data), .dq_out(dq_out), .dq_valid(dq_valid),
    .wait_out(wait_out), .cfg_err(cfg_err), .cfg_q(cfg_q)
  );

  typedef struct packed { logic v; logic w; logic [AW-1:0] a; } ent_t;
  ent_t q[$];
  ent_t cur = '0;
  logic [15:0] mcfg = 16'h09FF;
  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  function automatic logic [15:0] mk(input bit as, input logic [2:0] bl, input bit nw,
      input bit rise, input bit early, input bit h2, input bit wh, input logic [3:0] lat);
    return {3'b000, lat, wh, h2, early, rise, nw, bl, as};
  endfunction

  function automatic bit bl_reserved(input logic [2:0] bl);
    return !(bl == 3'd1 || bl == 3'd2 || bl == 3'd3 || bl == 3'd7);
  endfunction

  task automatic mstep(input logic st, input logic [AW-1:0] a);
    int L, H, N, E, words;
    bit cont, wrap, early_eff;
    logic [2:0] bl;
    logic [3:0] lat;
    if (mcfg[0]) begin q.delete(); cur = '0; return; end
    if (st) begin
      q.delete();
      bl = mcfg[3:1]; lat = mcfg[12:9];
      L = (lat < 2) ? 4 : int'(lat);
      H = mcfg[7] ? 2 : 1;
      cont = bl_reserved(bl) || bl == 3'd7;
      N = (bl == 3'd1) ? 4 : (bl == 3'd2) ? 8 : (bl == 3'd3) ? 16 : 0;
      early_eff = mcfg[6] && !(lat == 4'd2 && mcfg[7]);
      E = early_eff ? H : 0;
      wrap = !mcfg[4] && !cont;
      for (int j = 0; j < L - 1; j++) q.push_back({1'b0, (L - 1 - j) > E, {AW{1'b0}}});
      words = cont ? 300 : N;
      for (int i = 0; i < words; i++) begin
        int ad;
        if (wrap) ad = (int'(a) & ~(N - 1)) | ((int'(a) + i) & (N - 1));
        else ad = (int'(a) + i) & ((1 << AW) - 1);
        for (int h = 0; h < H; h++) q.push_back({1'b1, 1'b0, AW'(ad)});
      end
    end
    if (q.size() > 0) cur = q.pop_front();
    else cur = '0;
  endtask

  task automatic check();
    logic ev, ew, ee;
    logic [AW-1:0] ea;
    logic [15:0] ed;
    logic [3:0] lat;
    bit ok;
    lat = mcfg[12:9];
    ev = mcfg[0] ? 1'b1 : cur.v;
    ea = mcfg[0] ? s_addr : cur.a;
    ed = ev ? memf(ea) : 16'h0000;
    ew = mcfg[0] ? !mcfg[8] : (cur.w ? mcfg[8] : !mcfg[8]);
    ee = bl_reserved(mcfg[3:1]) || lat < 2 || (lat == 4'd2 && mcfg[7] && mcfg[6]);
    ok = (dq_valid === ev) && (dq_out === ed) && (wait_out === ew) &&
         (cfg_err === ee) && (cfg_q === mcfg) && (!ev || mem_addr === ea);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s t=%0t: act v=%b dq=%h w=%b err=%b cfg=%h addr=%h | exp v=%b dq=%h w=%b err=%b cfg=%h addr=%h",
               tag, $time, dq_valid, dq_out, wait_out, cfg_err, cfg_q, mem_addr,
               ev, ed, ew, ee, mcfg, ea);
    end
  endtask

  task automatic cyc(input logic st, input logic [AW-1:0] a,
                     input logic wr = 1'b0, input logic [15:0] wd = 16'h0);
    @(posedge clk);
    #0.5;
    s_strobe = st; s_addr = a; s_wr = wr; s_wdata = wd;
    if (!mcfg[5]) mstep(st, a);
    #3;
    check();
    if (mcfg[5]) mstep(st, a);
    if (wr) mcfg = wd & 16'h1FFF;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0);
  endtask

  task automatic wcfg(input logic [15:0] v);
    cyc(1'b0, 16'h0, 1'b1, v);
    idle(2);
  endtask

  task automatic burst(input logic [AW-1:0] a, input int n);
    cyc(1'b1, a);
    idle(n);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish (act hung, exp done)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R1"; idle(4);
    tag = "R2"; wcfg(16'hFFFF); wcfg(16'h09FF);
    tag = "R3";
    for (int i = 0; i < 8; i++) cyc(i[0], AW'(16'h1000 + i * 37));
    tag = "R4";
    wcfg(mk(0, 3'd1, 1, 1, 0, 0, 1, 4'd3)); burst(16'h0012, 10);
    wcfg(mk(0, 3'd1, 1, 1, 0, 0, 1, 4'd7)); burst(16'h0020, 14);
    tag = "R5";
    wcfg(mk(0, 3'd2, 1, 1, 0, 0, 1, 4'd3)); burst(16'h0036, 14);
    wcfg(mk(0, 3'd3, 1, 1, 0, 0, 1, 4'd3)); burst(16'h00F9, 22);
    tag = "R6";
    wcfg(mk(0, 3'd2, 0, 1, 0, 0, 1, 4'd3)); burst(16'h0105, 14);
    wcfg(mk(0, 3'd3, 0, 1, 0, 0, 1, 4'd3)); burst(16'h00FE, 22);
    wcfg(mk(0, 3'd1, 0, 1, 0, 0, 1, 4'd3)); burst(16'h0203, 10);
    tag = "R7";
    wcfg(mk(0, 3'd1, 1, 1, 0, 1, 1, 4'd5)); burst(16'h0400, 16);
    wcfg(mk(0, 3'd1, 0, 1, 0, 1, 1, 4'd5)); burst(16'h0402, 16);
    tag = "R8";
    wcfg(mk(0, 3'd1, 1, 1, 0, 0, 0, 4'd4)); burst(16'h0500, 12);
    tag = "R9";
    wcfg(mk(0, 3'd1, 1, 1, 1, 0, 1, 4'd4)); burst(16'h0600, 12);
    wcfg(mk(0, 3'd2, 1, 1, 1, 1, 0, 4'd4)); burst(16'h0610, 24);
    wcfg(mk(0, 3'd1, 1, 1, 1, 0, 1, 4'd2)); burst(16'h0620, 8);
    tag = "R10";
    wcfg(mk(0, 3'd1, 1, 1, 1, 1, 1, 4'd2)); burst(16'h0700, 14);
    tag = "R11";
    wcfg(mk(0, 3'd4, 0, 1, 0, 0, 1, 4'd3)); burst(16'hFFF8, 30);
    wcfg(mk(1, 3'd1, 1, 1, 0, 0, 1, 4'd3)); idle(2);
    wcfg(mk(0, 3'd1, 1, 1, 0, 0, 1, 4'd0)); burst(16'h0800, 12);
    tag = "R5";
    wcfg(mk(0, 3'd7, 1, 1, 0, 0, 1, 4'd3)); burst(16'hFFF0, 40);
    wcfg(mk(1, 3'd7, 1, 1, 0, 0, 1, 4'd3)); idle(2);
    tag = "R12";
    wcfg(mk(0, 3'd2, 1, 1, 0, 0, 1, 4'd5));
    burst(16'h0900, 2); burst(16'h0A00, 7); burst(16'h0B00, 16);
    tag = "R13";
    wcfg(mk(0, 3'd1, 1, 0, 0, 0, 1, 4'd3)); idle(2); burst(16'h0C00, 10);
    wcfg(mk(0, 3'd2, 0, 0, 1, 1, 0, 4'd4)); burst(16'h0C05, 24);
    burst(16'h0C10, 3); burst(16'h0C20, 24);
    wcfg(mk(0, 3'd1, 1, 1, 0, 0, 1, 4'd3)); idle(2); burst(16'h0D00, 10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule